// File: doc/BRIEF.md
# Byte-Addressed Partial-Word Access Unit

This block sits between a requester that works in byte addresses and a store that is organised in 32-bit words. It performs byte, halfword, word and doubleword reads and writes. Sub-word lanes are picked in big-endian order, so byte offset 0 is the most significant byte of a word. For a sub-word write to memory, the unit reads the target word, merges the new lane into it and writes the result back. A doubleword always uses an even/odd word pair.

The lowest byte addresses, those below 4 × `RF_WORDS`, reach a small register file instead of memory. These accesses skip the translation step and finish in one cycle. Every other address passes through a translation stage. In this project that stage is an identity stub, and its only effect is a fault input that turns the access into a trap. A sticky flag records that state has been altered by a write. Only reset clears it.

Requests and responses each use a valid/ready handshake. `req_ready` is high only when the unit is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. Exactly one access is in flight at a time. The response stays on `rsp_data` and `rsp_trap` with `rsp_valid` high until `rsp_ready` is seen. No new request is accepted until that response has been taken.

Top module: `pwa_unit`

## Requirements
- R1: Size code 0 is a byte access. Byte offset k (the address bits [1:0]) occupies word bits [31-8k:24-8k]. A byte read returns that lane zero-extended in `rsp_data[7:0]`.
- R2: Size code 1 is a halfword access. When address bit 1 is set, the access uses word bits [15:0]. When it is clear, the access uses bits [31:16]. The result is returned zero-extended in `rsp_data[15:0]`.
- R3: Size code 2 is a whole word, returned in `rsp_data[31:0]`. Size code 3 is a doubleword, and it ignores address bit 2. The even word of the pair maps to data bits [63:32] and the odd word to bits [31:0], for both reads and writes.
- R4: A byte address below 4 × `RF_WORDS` accesses register-file entry addr[5:2], never the memory. Its response is valid in the cycle after acceptance, and `xlt_fault` has no effect on it.
- R5: Byte and halfword writes leave every other bit of the target word unchanged, in memory and in the register file.
- R6: A sub-word memory write uses one memory read cycle followed by one write cycle. A word memory write uses one write cycle only. A doubleword memory write uses two write cycles. A memory read uses one read cycle, or two for a doubleword.
- R7: `state_altered` is set by every write that does not trap, whatever its size and target. It stays set until reset.
- R8: A memory-range request with `xlt_fault` high responds one cycle after acceptance with `rsp_trap`=1 and `rsp_data`=0. It performs no memory or register write and leaves `state_altered` unchanged.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` and `rsp_trap` hold steady and `req_ready` stays low.
- R10: After reset `req_ready`=1, `rsp_valid`=0 and `state_altered`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 2*DW | Write data; sub-word values right-aligned; doubleword even word high |
| xlt_fault | input | 1 | Translation fault for this request |
| mem_en | output | 1 | Memory cycle strobe |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | AW-2 | Memory word index |
| mem_wdata | output | DW | Memory write word |
| mem_rdata | input | DW | Memory read word, valid in the same cycle as mem_addr |
| rf_addr_a | output | log2(RF_WORDS) | Register index, first word (forced even for doubleword) |
| rf_addr_b | output | log2(RF_WORDS) | Register index, odd partner word |
| rf_rdata_a | input | DW | Register read data for rf_addr_a |
| rf_rdata_b | input | DW | Register read data for rf_addr_b |
| rf_we_a | output | 1 | Write rf_wdata_a at rf_addr_a |
| rf_we_b | output | 1 | Write rf_wdata_b at rf_addr_b |
| rf_wdata_a | output | DW | Register write word, first |
| rf_wdata_b | output | DW | Register write word, odd partner |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | 2*DW | Read result, zero for writes and traps |
| rsp_trap | output | 1 | Access aborted by translation fault |
| state_altered | output | 1 | Sticky write indicator |

## Verification
The assertions assume three things about the surroundings:
- The memory and register file return read data combinationally, in the same cycle as the index.
- Request fields are meaningful only in the cycle where the request is accepted.
- `rsp_ready` may be withheld for any number of cycles.

The stimulus meets these conditions as follows. It drives every request field and handshake input at the falling clock edge and holds them until the next edge. The memory and register models are wired combinationally. `rsp_ready` is held high except in one back-pressure test, where it is withheld for several cycles while the held response is watched.

// File: rtl/pwa_pkg.sv
package pwa_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD0,
    ST_RD1,
    ST_WR0,
    ST_WR1,
    ST_RSP
  } state_e;

endpackage

// File: rtl/pwa_lane.sv
// Big-endian lane extraction and merge for one data word.
module pwa_lane #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]    word_in,
  input  logic [1:0]       lo,
  input  pwa_pkg::size_e   size,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rd_val,
  output logic [DW-1:0]    merged
);
  localparam int BW = DW / 4;
  localparam int HW = DW / 2;
  localparam logic [DW-1:0] BMASK = {{(DW-BW){1'b0}}, {BW{1'b1}}};

  always_comb begin
    int sh;
    sh = (3 - int'(lo)) * BW;
    rd_val = word_in;
    merged = wdata;
    case (size)
      pwa_pkg::SZ_BYTE: begin
        rd_val = (word_in >> sh) & BMASK;
        merged = (word_in & ~(BMASK << sh)) | ((wdata & BMASK) << sh);
      end
      pwa_pkg::SZ_HALF: begin
        if (lo[1]) begin
          rd_val = {{HW{1'b0}}, word_in[HW-1:0]};
          merged = {word_in[DW-1:HW], wdata[HW-1:0]};
        end else begin
          rd_val = {{HW{1'b0}}, word_in[DW-1:HW]};
          merged = {wdata[HW-1:0], word_in[HW-1:0]};
        end
      end
      default: begin
        rd_val = word_in;
        merged = wdata;
      end
    endcase
  end
endmodule

// File: rtl/pwa_xlate.sv
// Translation stage stub: identity mapping, fault passed through.
module pwa_xlate #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] vaddr,
  input  logic          fault_in,
  output logic [AW-1:0] paddr,
  output logic          fault
);
  assign paddr = vaddr;
  assign fault = fault_in;
endmodule

// File: rtl/pwa_unit.sv
module pwa_unit #(
  parameter int AW       = 16,
  parameter int DW       = 32,
  parameter int RF_WORDS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [AW-1:0]               req_addr,
  input  logic [1:0]                  req_size,
  input  logic                        req_we,
  input  logic [2*DW-1:0]             req_wdata,
  input  logic                        xlt_fault,
  output logic                        mem_en,
  output logic                        mem_we,
  output logic [AW-3:0]               mem_addr,
  output logic [DW-1:0]               mem_wdata,
  input  logic [DW-1:0]               mem_rdata,
  output logic [$clog2(RF_WORDS)-1:0] rf_addr_a,
  output logic [$clog2(RF_WORDS)-1:0] rf_addr_b,
  input  logic [DW-1:0]               rf_rdata_a,
  input  logic [DW-1:0]               rf_rdata_b,
  output logic                        rf_we_a,
  output logic                        rf_we_b,
  output logic [DW-1:0]               rf_wdata_a,
  output logic [DW-1:0]               rf_wdata_b,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic [2*DW-1:0]             rsp_data,
  output logic                        rsp_trap,
  output logic                        state_altered
);
  import pwa_pkg::*;

  localparam int RFIW      = $clog2(RF_WORDS);
  localparam int WIW       = AW - 2;
  localparam int REG_LIMIT = RF_WORDS * 4;

  state_e          state;
  size_e           req_sz, q_size;
  logic            q_we;
  logic [1:0]      q_lo;
  logic [WIW-1:0]  q_widx;
  logic [2*DW-1:0] q_wdata;
  logic [DW-1:0]   q_w0, q_merge;

  logic            accept, is_reg, req_dbl, x_fault;
  logic [AW-1:0]   paddr;
  logic [RFIW-1:0] ridx;
  logic [WIW-1:0]  even_idx, odd_idx;

  logic [DW-1:0]   lane_word, lane_wd, lane_rd, lane_merged;
  logic [1:0]      lane_lo;
  size_e           lane_size;

  assign req_sz   = size_e'(req_size);
  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RSP);
  assign accept   = req_valid && req_ready;
  assign is_reg   = req_addr < AW'(REG_LIMIT);
  assign req_dbl  = (req_sz == SZ_DBL);
  assign ridx     = req_addr[RFIW+1:2];
  assign even_idx = {q_widx[WIW-1:1], 1'b0};
  assign odd_idx  = {q_widx[WIW-1:1], 1'b1};

  pwa_xlate #(.AW(AW)) u_xlate (
    .vaddr    (req_addr),
    .fault_in (xlt_fault),
    .paddr    (paddr),
    .fault    (x_fault)
  );

  // One lane unit: register path while idle, memory path afterwards.
  always_comb begin
    if (state == ST_IDLE) begin
      lane_word = rf_rdata_a;
      lane_lo   = req_addr[1:0];
      lane_size = req_sz;
      lane_wd   = req_wdata[DW-1:0];
    end else begin
      lane_word = mem_rdata;
      lane_lo   = q_lo;
      lane_size = q_size;
      lane_wd   = q_wdata[DW-1:0];
    end
  end

  pwa_lane #(.DW(DW)) u_lane (
    .word_in (lane_word),
    .lo      (lane_lo),
    .size    (lane_size),
    .wdata   (lane_wd),
    .rd_val  (lane_rd),
    .merged  (lane_merged)
  );

  // Register-file port: single-cycle access during acceptance.
  assign rf_addr_a  = req_dbl ? {ridx[RFIW-1:1], 1'b0} : ridx;
  assign rf_addr_b  = {ridx[RFIW-1:1], 1'b1};
  assign rf_we_a    = accept && is_reg && req_we;
  assign rf_we_b    = rf_we_a && req_dbl;
  assign rf_wdata_a = req_dbl ? req_wdata[2*DW-1:DW] :
                      (req_sz == SZ_WORD) ? req_wdata[DW-1:0] : lane_merged;
  assign rf_wdata_b = req_wdata[DW-1:0];

  // Memory port driven by the sequencing state.
  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = q_widx;
    mem_wdata = '0;
    case (state)
      ST_RD0: begin
        mem_en   = 1'b1;
        mem_addr = (q_size == SZ_DBL) ? even_idx : q_widx;
      end
      ST_RD1: begin
        mem_en   = 1'b1;
        mem_addr = odd_idx;
      end
      ST_WR0: begin
        mem_en   = 1'b1;
        mem_we   = 1'b1;
        mem_addr = (q_size == SZ_DBL) ? even_idx : q_widx;
        mem_wdata = (q_size == SZ_DBL)  ? q_wdata[2*DW-1:DW] :
                    (q_size == SZ_WORD) ? q_wdata[DW-1:0] : q_merge;
      end
      ST_WR1: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = odd_idx;
        mem_wdata = q_wdata[DW-1:0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      q_size        <= SZ_BYTE;
      q_we          <= 1'b0;
      q_lo          <= '0;
      q_widx        <= '0;
      q_wdata       <= '0;
      q_w0          <= '0;
      q_merge       <= '0;
      rsp_data      <= '0;
      rsp_trap      <= 1'b0;
      state_altered <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          q_size  <= req_sz;
          q_we    <= req_we;
          q_lo    <= paddr[1:0];
          q_widx  <= paddr[AW-1:2];
          q_wdata <= req_wdata;
          if (is_reg) begin
            rsp_trap <= 1'b0;
            if (req_we) begin
              rsp_data      <= '0;
              state_altered <= 1'b1;
            end else if (req_dbl) begin
              rsp_data <= {rf_rdata_a, rf_rdata_b};
            end else begin
              rsp_data <= {{DW{1'b0}}, lane_rd};
            end
            state <= ST_RSP;
          end else if (x_fault) begin
            rsp_trap <= 1'b1;
            rsp_data <= '0;
            state    <= ST_RSP;
          end else begin
            rsp_trap <= 1'b0;
            state <= (req_we && (req_sz == SZ_WORD || req_dbl)) ? ST_WR0 : ST_RD0;
          end
        end
        ST_RD0: begin
          if (q_we) begin
            q_merge <= lane_merged;
            state   <= ST_WR0;
          end else if (q_size == SZ_DBL) begin
            q_w0  <= mem_rdata;
            state <= ST_RD1;
          end else begin
            rsp_data <= {{DW{1'b0}}, lane_rd};
            state    <= ST_RSP;
          end
        end
        ST_RD1: begin
          rsp_data <= {q_w0, mem_rdata};
          state    <= ST_RSP;
        end
        ST_WR0: begin
          if (q_size == SZ_DBL) begin
            state <= ST_WR1;
          end else begin
            rsp_data      <= '0;
            state_altered <= 1'b1;
            state         <= ST_RSP;
          end
        end
        ST_WR1: begin
          rsp_data      <= '0;
          state_altered <= 1'b1;
          state         <= ST_RSP;
        end
        ST_RSP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: a held response does not change
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_trap)));

  // R4: register-range request answers on the next cycle
  p_reg_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_addr < AW'(REG_LIMIT))) |=> rsp_valid);

  // R7: flag never drops outside reset
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state_altered |=> state_altered);

  // R8: a trapped response leaves the flag untouched
  p_trap_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && rsp_trap) |-> $stable(state_altered));

  // R6: sub-word memory writes come right after a read cycle
  p_rmw_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && (q_size == SZ_BYTE || q_size == SZ_HALF))
      |-> $past(mem_en && !mem_we));

endmodule

// File: tb/sim_pwa_unit.sv
module sim_pwa_unit;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [15:0] addr;
    logic [1:0]  size;
    logic        we;
    logic        flt;
    logic [63:0] wd;
    logic [2:0]  lat;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{16'h0100, 2'd2, 1'b0, 1'b0, 64'h0, 3'd2, 4'd3},               // R3 word read
    '{16'h0101, 2'd0, 1'b0, 1'b0, 64'h0, 3'd2, 4'd1},               // R1 byte 1
    '{16'h0103, 2'd0, 1'b0, 1'b0, 64'h0, 3'd2, 4'd1},               // R1 byte 3
    '{16'h0102, 2'd1, 1'b0, 1'b0, 64'h0, 3'd2, 4'd2},               // R2 low half
    '{16'h0100, 2'd1, 1'b0, 1'b0, 64'h0, 3'd2, 4'd2},               // R2 high half
    '{16'h0104, 2'd3, 1'b0, 1'b0, 64'h0, 3'd3, 4'd3},               // R3 dbl, bit2 set
    '{16'h0108, 2'd3, 1'b0, 1'b0, 64'h0, 3'd3, 4'd3},               // R3 dbl aligned
    '{16'h0105, 2'd0, 1'b1, 1'b0, 64'h5A, 3'd3, 4'd5},              // R5 byte write
    '{16'h0104, 2'd2, 1'b0, 1'b0, 64'h0, 3'd2, 4'd5},               // R5 readback
    '{16'h010E, 2'd1, 1'b1, 1'b0, 64'hBEEF, 3'd3, 4'd5},            // R5 half write
    '{16'h010C, 2'd2, 1'b0, 1'b0, 64'h0, 3'd2, 4'd5},               // R5 readback
    '{16'h0114, 2'd3, 1'b1, 1'b0, 64'h11111111_22222222, 3'd3, 4'd3}, // R3 dbl write
    '{16'h0110, 2'd3, 1'b0, 1'b0, 64'h0, 3'd3, 4'd3},               // R3 readback
    '{16'h0020, 2'd2, 1'b0, 1'b0, 64'h0, 3'd1, 4'd4},               // R4 reg read
    '{16'h0022, 2'd0, 1'b1, 1'b1, 64'h77, 3'd1, 4'd4},              // R4 fault ignored
    '{16'h0020, 2'd2, 1'b0, 1'b0, 64'h0, 3'd1, 4'd5},               // R5 reg merge
    '{16'h003C, 2'd3, 1'b0, 1'b0, 64'h0, 3'd1, 4'd4},               // R4 reg dbl
    '{16'h0018, 2'd3, 1'b1, 1'b0, 64'hCAFE0001_D00D0002, 3'd1, 4'd4}, // R4 reg dbl write
    '{16'h001C, 2'd2, 1'b0, 1'b0, 64'h0, 3'd1, 4'd3},               // R3 odd partner
    '{16'h0200, 2'd2, 1'b1, 1'b1, 64'hFFFF, 3'd1, 4'd8},            // R8 trapped write
    '{16'h0200, 2'd2, 1'b0, 1'b0, 64'h0, 3'd2, 4'd8},               // R8 unchanged
    '{16'h0120, 2'd2, 1'b1, 1'b0, 64'h0BADF00D, 3'd2, 4'd6},        // R6 word write
    '{16'h0120, 2'd2, 1'b0, 1'b0, 64'h0, 3'd2, 4'd6},               // R6 readback
    '{16'h0100, 2'd1, 1'b1, 1'b0, 64'h1234, 3'd3, 4'd2},            // R2 high half write
    '{16'h0100, 2'd2, 1'b0, 1'b0, 64'h0, 3'd2, 4'd2},               // R2 readback
    '{16'h0108, 2'd0, 1'b1, 1'b0, 64'hC3, 3'd3, 4'd1},              // R1 byte 0 write
    '{16'h0108, 2'd2, 1'b0, 1'b0, 64'h0, 3'd2, 4'd1}                // R1 readback
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_we = 1'b0;
  logic [63:0] req_wdata = '0;
  logic        xlt_fault = 1'b0;
  logic        mem_en, mem_we;
  logic [13:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0]  rf_addr_a, rf_addr_b;
  logic [31:0] rf_rdata_a, rf_rdata_b, rf_wdata_a, rf_wdata_b;
  logic        rf_we_a, rf_we_b;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_data;
  logic        rsp_trap;
  logic        state_altered;

  logic [31:0] mem_m [256];
  logic [31:0] rf_m  [16];
  logic [31:0] emem  [256];
  logic [31:0] erf   [16];
  int nrd_c = 0, nwr_c = 0;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  pwa_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_we(req_we), .req_wdata(req_wdata), .xlt_fault(xlt_fault),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rf_addr_a(rf_addr_a), .rf_addr_b(rf_addr_b),
    .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b),
    .rf_we_a(rf_we_a), .rf_we_b(rf_we_b),
    .rf_wdata_a(rf_wdata_a), .rf_wdata_b(rf_wdata_b),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_trap(rsp_trap),
    .state_altered(state_altered)
  );

  function automatic logic [31:0] seed(int i, int k);
    return (32'h9E3779B9 * 32'(i + 1)) + 32'(k);
  endfunction

  assign mem_rdata  = mem_m[mem_addr[7:0]];
  assign rf_rdata_a = rf_m[rf_addr_a];
  assign rf_rdata_b = rf_m[rf_addr_b];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem_m[i] <= seed(i, 0);
      for (int i = 0; i < 16; i++)  rf_m[i]  <= seed(i, 7);
    end else begin
      if (mem_en && mem_we) mem_m[mem_addr[7:0]] <= mem_wdata;
      if (mem_en) begin
        if (mem_we) nwr_c <= nwr_c + 1;
        else        nrd_c <= nrd_c + 1;
      end
      if (rf_we_a) rf_m[rf_addr_a] <= rf_wdata_a;
      if (rf_we_b) rf_m[rf_addr_b] <= rf_wdata_b;
    end
  end

  task automatic chk(input bit ok, input string tg, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tg, what, act, exp);
    end
  endtask

  function automatic logic [31:0] eget(bit isreg, int idx);
    return isreg ? erf[idx] : emem[idx];
  endfunction

  task automatic eput(bit isreg, int idx, logic [31:0] v);
    if (isreg) erf[idx] = v; else emem[idx] = v;
  endtask

  // Reference behaviour taken from the requirements.
  task automatic model(input logic [15:0] a, input logic [1:0] sz, input logic we,
                       input logic flt, input logic [63:0] wd,
                       output logic [63:0] rd, output logic trap,
                       output int nrd, output int nwr);
    bit isreg;
    int idx, sh;
    logic [31:0] w, nw;
    isreg = (a < 16'd64);
    idx   = isreg ? int'(a[5:2]) : int'(a[9:2]);
    trap  = !isreg && flt;
    rd = '0; nrd = 0; nwr = 0;
    if (trap) return;
    w  = eget(isreg, idx);
    sh = 24 - 8 * int'(a[1:0]);
    if (!we) begin
      case (sz)
        2'd0: rd = {32'h0, (w >> sh) & 32'hFF};
        2'd1: rd = {48'h0, a[1] ? w[15:0] : w[31:16]};
        2'd2: rd = {32'h0, w};
        default: rd = {eget(isreg, idx & ~1), eget(isreg, idx | 1)};
      endcase
      if (!isreg) nrd = (sz == 2'd3) ? 2 : 1;
    end else begin
      case (sz)
        2'd0: begin
          nw = (w & ~(32'hFF << sh)) | ({24'h0, wd[7:0]} << sh);
          eput(isreg, idx, nw);
        end
        2'd1: begin
          nw = a[1] ? {w[31:16], wd[15:0]} : {wd[15:0], w[15:0]};
          eput(isreg, idx, nw);
        end
        2'd2: eput(isreg, idx, wd[31:0]);
        default: begin
          eput(isreg, idx & ~1, wd[63:32]);
          eput(isreg, idx | 1, wd[31:0]);
        end
      endcase
      if (!isreg) begin
        nwr = (sz == 2'd3) ? 2 : 1;
        nrd = (sz < 2'd2) ? 1 : 0;
      end
    end
  endtask

  task automatic run(input logic [15:0] a, input logic [1:0] sz, input logic we,
                     input logic flt, input logic [63:0] wd, input int lat, input string tg);
    logic [63:0] erd;
    logic etrap;
    int enr, enw, r0, w0, n;
    model(a, sz, we, flt, wd, erd, etrap, enr, enw);
    @(negedge clk);
    r0 = nrd_c; w0 = nwr_c;
    req_addr = a; req_size = sz; req_we = we; req_wdata = wd; xlt_fault = flt;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; xlt_fault = 1'b0;
    n = 1;
    while (!rsp_valid && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(rsp_valid && n == lat, tg, "latency", 64'(n), 64'(lat));
    chk(rsp_data == erd, tg, "data", rsp_data, erd);
    chk(rsp_trap == etrap, tg, "trap", 64'(rsp_trap), 64'(etrap));
    chk((nrd_c - r0) == enr && (nwr_c - w0) == enw, tg, "mem cycles rd/wr",
        {32'(nrd_c - r0), 32'(nwr_c - w0)}, {32'(enr), 32'(enw)});
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] held;
    for (int i = 0; i < 256; i++) emem[i] = seed(i, 0);
    for (int i = 0; i < 16; i++)  erf[i]  = seed(i, 7);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(req_ready == 1'b1, "R10", "req_ready", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R10", "rsp_valid", 64'(rsp_valid), 64'd0);
    chk(state_altered == 1'b0, "R10", "state_altered", 64'(state_altered), 64'd0);

    // R8: trapped write leaves the flag clear
    run(16'h0300, 2'd2, 1'b1, 1'b1, 64'h12345678, 1, "R8");
    chk(state_altered == 1'b0, "R8", "flag after trap", 64'(state_altered), 64'd0);
    // R7: reads do not set it, a register write does
    run(16'h0010, 2'd2, 1'b0, 1'b0, 64'h0, 1, "R7");
    chk(state_altered == 1'b0, "R7", "flag after read", 64'(state_altered), 64'd0);
    run(16'h000C, 2'd2, 1'b1, 1'b0, 64'hA5A5A5A5, 1, "R7");
    chk(state_altered == 1'b1, "R7", "flag after write", 64'(state_altered), 64'd1);

    for (int v = 0; v < NV; v++)
      run(VEC[v].addr, VEC[v].size, VEC[v].we, VEC[v].flt, VEC[v].wd,
          int'(VEC[v].lat), $sformatf("R%0d", VEC[v].tag));

    // R9: back-pressure on the response
    @(negedge clk);
    rsp_ready = 1'b0;
    req_addr = 16'h0100; req_size = 2'd2; req_we = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    held = rsp_data;
    chk(rsp_valid == 1'b1, "R9", "valid under stall", 64'(rsp_valid), 64'd1);
    chk(held == {32'h0, emem[64]}, "R9", "stalled data", held, {32'h0, emem[64]});
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rsp_valid && !req_ready && rsp_data == held, "R9", "hold",
          rsp_data, held);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R9", "release",
        {62'h0, rsp_valid, req_ready}, 64'd1);

    // R7 still set; R5/R8 whole-store comparison
    chk(state_altered == 1'b1, "R7", "flag sticky", 64'(state_altered), 64'd1);
    begin
      int mis;
      mis = 0;
      for (int i = 0; i < 256; i++) if (mem_m[i] !== emem[i]) mis++;
      chk(mis == 0, "R5", "memory image mismatches", 64'(mis), 64'd0);
      mis = 0;
      for (int i = 0; i < 16; i++) if (rf_m[i] !== erf[i]) mis++;
      chk(mis == 0, "R4", "register image mismatches", 64'(mis), 64'd0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule